// File: doc/BRIEF.md
# Streaming SPI Master with FIFO Level Interrupts

This block is an SPI master (clock mode 0, MSB first, one chip select) that moves a programmed number of bytes in a single burst. Software loads bytes into a transmit FIFO and collects received bytes from a receive FIFO through a small word-wide register port. A burst may be far longer than either FIFO. Software keeps the burst going by topping up the transmit side and draining the receive side when the level interrupts ask for service.

The level interrupts follow the FIFO conditions. Clearing a status bit while its condition still holds has no lasting effect, because the bit sets again on the next cycle. When the receive-hold option is on, the shifter stops before a byte whose result would find no room in the receive FIFO. If the transmit FIFO runs dry in the middle of a burst, the shifter also stops with the serial clock low. No filler byte is sent in either case.

Register map (byte offsets on `bus_addr`): 0x00 receive data (a read pops one byte), 0x04 transmit data (a write pushes one byte), 0x08 control (bit 18 receive-hold, bit 10 go, which reads back as busy), 0x0c interrupt enable, 0x10 interrupt status (write 1 to clear), 0x24 burst length (bits 23:0), 0x28 FIFO levels (receive count in bits 6:0, transmit count in bits 22:16). Status and enable bits: 4 = receive level high, 12 = transmit level low, 16 = burst done, 20 = transmit overflow.

Top module: `spi_stream_master`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, irq is 0, both FIFO counts at 0x28 read 0, and the enable register at 0x0c reads 0.
- R2: Writing 0x08 with bit 10 set starts a burst of the length held at 0x24. Each byte is taken from the transmit FIFO and shifted out MSB first on mosi, with each bit stable at the rising edge of sclk. Each received byte, sampled from miso on the rising edges, is pushed to the receive FIFO in the order received.
- R3: Status bit 16 sets only after the full programmed byte count has been shifted. cs_n then returns to 1. A burst length of 0 sets bit 16 without any sclk edge.
- R4: Status bit 4 is set whenever the receive count is 48 or more. Writing 1 to it while the count is 48 or more leaves it set, and writing 1 to it while the count is below 48 clears it.
- R5: Status bit 12 is set whenever the transmit count is 16 or fewer. It re-asserts after a write-1 clear while that still holds, and it clears when written while the count is above 16.
- R6: With control bit 18 set, no byte is started while the receive FIFO holds 64 bytes. sclk stays idle and cs_n stays 0 until a read frees space, and then the burst continues with no received byte lost.
- R7: With control bit 18 clear, a byte that completes while the receive FIFO is full is discarded. The FIFO keeps its 64 earlier bytes unchanged.
- R8: A write to 0x04 while the transmit FIFO holds 64 bytes is dropped, leaves the count at 64, and sets sticky status bit 20, which stays set until written with 1.
- R9: Reading 0x00 while the receive FIFO is empty returns 0.
- R10: If the transmit FIFO is empty in mid-burst, the shifter waits with sclk low and status bit 16 clear, and resumes when bytes are written.
- R11: irq is 1 exactly when some status bit is set together with its enable bit at 0x0c.
- R12: Register 0x28 reports the receive count in bits 6:0 and the transmit count in bits 22:16, each from 0 to 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; pops the receive FIFO at 0x00 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Active-high interrupt, OR of enabled status bits |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select, low for the whole burst |

## Verification
The assertions assume at most one register access per cycle and no go command while a burst is in progress. They also assume that miso settles before the cycle in which sclk rises. The bench drives the register port only through single-access tasks, starts a burst only after the previous one reports done, and feeds miso as the inverse of mosi. This makes every received byte predictable from the byte sent. Data bytes are drawn from a fixed-seed random stream. The FIFO-full, FIFO-empty, threshold-boundary and zero-length cases are reached by directed sequences.

// File: rtl/spi_stream_master.sv
module spi_stream_master #(
  parameter int DEPTH = 64,
  parameter int HALF  = 2,
  parameter int LENW  = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] HI   = CW'(DEPTH * 3 / 4);
  localparam logic [CW-1:0] LO   = CW'(DEPTH / 4);
  localparam int B_RXHI = 4, B_TXLO = 12, B_DONE = 16, B_OVF = 20, B_HOLD = 18, B_GO = 10;
  localparam logic [31:0] SMASK = 32'h0011_1010;
  localparam logic [7:0] A_RXD = 8'h00, A_TXD = 8'h04, A_CTL = 8'h08, A_IEN = 8'h0c,
                         A_STS = 8'h10, A_LEN = 8'h24, A_LVL = 8'h28;

  logic [7:0]      txm [DEPTH];
  logic [7:0]      rxm [DEPTH];
  logic [AW-1:0]   tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic            hold, busy, loaded;
  logic [LENW-1:0] len, left;
  logic [31:0]     ien, sts, sset, sclr;
  logic [7:0]      sh, rsh;
  logic [3:0]      ph;
  logic [HW-1:0]   dc;

  wire wr_tx   = bus_wr && bus_addr == A_TXD;
  wire tx_push = wr_tx && tx_cnt != FULL;
  wire tx_ovf  = wr_tx && tx_cnt == FULL;
  wire rx_pop  = bus_rd && bus_addr == A_RXD && rx_cnt != '0;
  wire start   = bus_wr && bus_addr == A_CTL && bus_wdata[B_GO] && !busy;
  wire can_go  = busy && !loaded && left != '0 && tx_cnt != '0 && !(hold && rx_cnt == FULL);
  wire tick    = busy && loaded && dc == HW'(HALF - 1);
  wire rx_push = tick && ph == 4'd15 && rx_cnt != FULL;
  wire finish  = busy && !loaded && left == '0;

  assign cs_n = ~busy;
  assign mosi = sh[7];
  assign irq  = |(sts & ien);

  always_ff @(posedge clk) begin
    if (tx_push) txm[tx_wp] <= bus_wdata[7:0];
    if (rx_push) rxm[rx_wp] <= rsh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; rx_wp <= '0; rx_rp <= '0;
      tx_cnt <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (can_go)  tx_rp <= tx_rp + 1'b1;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(can_go);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; loaded <= 1'b0; left <= '0; ph <= '0; dc <= '0;
      sh <= '0; rsh <= '0; sclk <= 1'b0;
    end else begin
      if (start)       begin busy <= 1'b1; left <= len; end
      else if (finish) busy <= 1'b0;
      if (can_go) begin
        loaded <= 1'b1; sh <= txm[tx_rp]; ph <= '0; dc <= '0;
      end else if (busy && loaded) begin
        dc <= tick ? '0 : dc + 1'b1;
        if (tick) begin
          ph <= ph + 1'b1;
          if (!ph[0]) begin sclk <= 1'b1; rsh <= {rsh[6:0], miso}; end
          else        begin sclk <= 1'b0; sh <= {sh[6:0], 1'b0}; end
          if (ph == 4'd15) begin loaded <= 1'b0; left <= left - LENW'(1); end
        end
      end
    end
  end

  always_comb begin
    sset = '0;
    sset[B_RXHI] = rx_cnt >= HI;
    sset[B_TXLO] = tx_cnt <= LO;
    sset[B_DONE] = finish;
    sset[B_OVF]  = tx_ovf;
    sclr = (bus_wr && bus_addr == A_STS) ? (bus_wdata & SMASK) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= 1'b0; len <= '0; ien <= '0; sts <= '0;
    end else begin
      if (bus_wr && bus_addr == A_CTL) hold <= bus_wdata[B_HOLD];
      if (bus_wr && bus_addr == A_LEN) len <= bus_wdata[LENW-1:0];
      if (bus_wr && bus_addr == A_IEN) ien <= bus_wdata & SMASK;
      sts <= (sts & ~sclr) | sset;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_RXD: if (rx_cnt != '0) bus_rdata[7:0] = rxm[rx_rp];
      A_CTL: begin bus_rdata[B_HOLD] = hold; bus_rdata[B_GO] = busy; end
      A_IEN: bus_rdata = ien;
      A_STS: bus_rdata = sts;
      A_LEN: bus_rdata[LENW-1:0] = len;
      A_LVL: begin bus_rdata[0 +: CW] = rx_cnt; bus_rdata[16 +: CW] = tx_cnt; end
      default: bus_rdata = '0;
    endcase
  end

  a_r6_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !loaded && hold && rx_cnt == FULL) |=> !loaded);
  a_r10_wait_when_dry: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !loaded && tx_cnt == '0) |=> (!loaded && !sclk));
  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf |=> sts[B_OVF]);
  a_r5_tx_level: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= LO) |=> sts[B_TXLO]);
  a_r4_rx_level: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt >= HI) |=> sts[B_RXHI]);
  a_r3_idle_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  a_r12_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= FULL && rx_cnt <= FULL));
endmodule

// File: tb/spi_stream_master_bench.sv
module spi_stream_master_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, sclk, mosi, cs_n;
  wire miso = ~mosi;

  always #10 clk = ~clk;

  spi_stream_master u_spi_stream_master (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  int checks = 0, errors = 0, ecount = 0, capn = 0, txn = 0, rxi = 0, bitn = 0;
  logic [7:0] txlog [0:255];
  logic [7:0] cap [0:255];
  logic [7:0] mbyte = '0;
  logic [31:0] rv;
  bit finished = 0;

  always @(posedge sclk) begin
    ecount++;
    mbyte = {mbyte[6:0], mosi};
    bitn++;
    if (bitn == 8) begin cap[capn] = mbyte; capn++; bitn = 0; end
  end

  function automatic logic [7:0] exp_rx(input logic [7:0] b);
    return ~b;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #5 rv = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic push_rand(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      txlog[txn] = b; txn++;
      wr(8'h04, {24'h0, b});
    end
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000; i++) begin
      rd(8'h10);
      if (rv[16]) break;
    end
  endtask

  task automatic pull_check(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      rd(8'h00);
      check(req, rv, {24'h0, exp_rx(txlog[rxi])});
      rxi++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int e0;
    rv = $urandom(32'd1234);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 cs_n", {31'h0, cs_n}, 32'h1);
    check("R1 sclk", {31'h0, sclk}, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    rd(8'h28); check("R1 levels", rv, 32'h0);
    rd(8'h0c); check("R1 enables", rv, 32'h0);

    // R5: low-level bit re-asserts after clearing while transmit FIFO is empty
    wr(8'h10, 32'h0000_1000);
    rd(8'h10); check("R5 reassert", rv & 32'h1000, 32'h1000);
    push_rand(20);
    rd(8'h28); check("R12 tx count 20", rv, 32'h0014_0000);
    wr(8'h10, 32'h0000_1000);
    rd(8'h10); check("R5 clears above 16", rv & 32'h1000, 32'h0);

    // R8: overflow on a full transmit FIFO, and R11 interrupt gating
    push_rand(44);
    wr(8'h04, 32'h0000_00a5);
    rd(8'h28); check("R8 count stays 64", rv, 32'h0040_0000);
    rd(8'h10); check("R8 overflow set", rv & 32'h10_0000, 32'h10_0000);
    check("R11 irq masked", {31'h0, irq}, 32'h0);
    wr(8'h0c, 32'h0010_0000); #1;
    check("R11 irq enabled", {31'h0, irq}, 32'h1);
    wr(8'h0c, 32'h0); #1;
    check("R11 irq disabled", {31'h0, irq}, 32'h0);
    rd(8'h10); check("R8 still sticky", rv & 32'h10_0000, 32'h10_0000);
    wr(8'h10, 32'h0010_0000);
    rd(8'h10); check("R8 cleared", rv & 32'h10_0000, 32'h0);

    // R2/R3/R4: 64-byte burst with receive hold on
    wr(8'h24, 32'd64);
    wr(8'h08, 32'h0004_0400);
    wait_done();
    check("R3 done", rv & 32'h1_0000, 32'h1_0000);
    #1 check("R3 cs_n released", {31'h0, cs_n}, 32'h1);
    rd(8'h28); check("R2 rx count 64", rv, 32'h0000_0040);
    rd(8'h10); check("R4 high set", rv & 32'h10, 32'h10);
    wr(8'h0c, 32'h0000_0010); #1;
    check("R11 irq on level", {31'h0, irq}, 32'h1);
    wr(8'h0c, 32'h0);
    wr(8'h10, 32'h0000_0010);
    rd(8'h10); check("R4 stays at 64", rv & 32'h10, 32'h10);
    pull_check("R2 rx data", 16);
    wr(8'h10, 32'h0000_0010);
    rd(8'h10); check("R4 stays at 48", rv & 32'h10, 32'h10);
    pull_check("R2 rx data", 1);
    wr(8'h10, 32'h0000_0010);
    rd(8'h10); check("R4 clears at 47", rv & 32'h10, 32'h0);
    pull_check("R2 rx data", 47);
    rd(8'h00); check("R9 empty read", rv, 32'h0);

    // R6: hold on full receive FIFO within an 80-byte burst
    wr(8'h10, 32'h0011_1010);
    push_rand(64);
    wr(8'h24, 32'd80);
    wr(8'h08, 32'h0004_0400);
    for (int i = 0; i < 5000; i++) begin
      rd(8'h28);
      if (rv[6:0] == 7'd64) break;
    end
    push_rand(16);
    e0 = ecount;
    repeat (100) @(negedge clk);
    check("R6 no clock while full", ecount, e0);
    check("R6 cs_n held", {31'h0, cs_n}, 32'h0);
    rd(8'h10); check("R3 not done early", rv & 32'h1_0000, 32'h0);
    pull_check("R6 rx data", 64);
    wait_done();
    pull_check("R6 rx data after resume", 16);
    rd(8'h28); check("R6 nothing lost", rv, 32'h0);

    // R10: transmit FIFO runs dry mid-burst
    wr(8'h10, 32'h0011_1010);
    wr(8'h24, 32'd4);
    push_rand(2);
    e0 = ecount;
    wr(8'h08, 32'h0004_0400);
    repeat (150) @(negedge clk);
    check("R10 two bytes clocked", ecount - e0, 16);
    check("R10 sclk low", {31'h0, sclk}, 32'h0);
    check("R10 cs_n held", {31'h0, cs_n}, 32'h0);
    rd(8'h10); check("R10 not done", rv & 32'h1_0000, 32'h0);
    push_rand(2);
    wait_done();
    check("R10 done after refill", rv & 32'h1_0000, 32'h1_0000);
    pull_check("R10 rx data", 4);

    // R7: no hold, overrun bytes discarded
    wr(8'h08, 32'h0);
    wr(8'h10, 32'h0011_1010);
    push_rand(64);
    wr(8'h24, 32'd70);
    wr(8'h08, 32'h0000_0400);
    for (int i = 0; i < 5000; i++) begin
      rd(8'h28);
      if (rv[22:16] <= 7'd10) break;
    end
    push_rand(6);
    wait_done();
    rd(8'h28); check("R7 rx count capped", rv, 32'h0000_0040);
    pull_check("R7 kept bytes", 64);
    rxi += 6;
    rd(8'h28); check("R7 extra bytes dropped", rv, 32'h0);

    // R3: zero-length burst
    wr(8'h10, 32'h0011_1010);
    wr(8'h24, 32'd0);
    e0 = ecount;
    wr(8'h08, 32'h0000_0400);
    repeat (4) @(negedge clk);
    rd(8'h10); check("R3 zero length done", rv & 32'h1_0000, 32'h1_0000);
    check("R3 zero length no clock", ecount, e0);

    // R2: every byte shifted out in order, MSB first
    check("R2 mosi byte count", capn, txn);
    begin
      int bad = 0;
      for (int i = 0; i < txn; i++) if (cap[i] !== txlog[i]) bad++;
      check("R2 mosi bytes", bad, 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule